// File: doc/BRIEF.md
# DMA Bus-Ownership Controller

This block is the ownership core of a four-channel DMA engine. It decides when the DMA side holds the system bus and when the bus goes back to the processor. Each channel has a control register, a unit counter and an incrementing address pointer. A channel asks for service either from its external request line or by itself (auto-request). A fixed-priority arbiter picks one eligible channel, and the engine then runs a request/grant handshake with the processor. Each transfer unit is one read cycle followed by one write cycle, and both cycles need the grant to be held.

A channel runs in one of two ownership modes. In burst mode the bus is kept from grant until the channel's whole count is done. In cycle-steal mode the bus is handed back after every unit, and the channels are arbitrated again before the next one. A rising edge on the non-maskable interrupt input always sets a sticky flag. If a transfer is running when that edge arrives, the transfer is aborted at once and the bus is released. No channel can start until software clears the flag.

The bus handshake has no data payload, so there is no back-pressure beyond the grant. `bus_req` stays high while the engine wants the bus. The engine advances only in cycles where `bus_gnt` is high. Removing the grant stalls the current phase without losing it.

Top module: `dma_busown_ctrl`

## Requirements
- R1: Register writes take the low byte only when `reg_byte` is high. The global register (0x00) and each channel control register accept byte writes. A byte write to a count register or an address register leaves it unchanged. A word write to either one loads all 16 bits.
- R2: Each channel has a register block at 0x10·(c+1). Its control register is at offset 0, with bit0 enable, bit1 burst, bits3:2 source and bit4 end flag. Source 0 selects the channel's request line, 1 selects auto-request, and 2 or 3 never request. A control write whose source value differs from the stored one is discarded completely while the enable bit is 1. The same write is accepted while the enable bit is 0.
- R3: Each unit is one `bus_rd` cycle followed by one `bus_wr` cycle. `bus_addr` is the channel's address register (offset 8), which increments after each unit. The count register (offset 4) decrements after each unit. In burst mode `bus_req` rises once and stays high until the count reaches zero.
- R4: In cycle-steal mode `bus_req` goes low for at least one cycle after every unit, so an N-unit transfer produces N rising edges of `bus_req`.
- R5: At each arbitration, the eligible channel with the lowest index wins.
- R6: When the last unit completes, the channel clears its enable bit, sets its end flag and pulses its `eot_irq` bit high for exactly one cycle. A control write with bit4 = 0 clears the end flag.
- R7: A rising edge on `nmi_in` sets the NMI flag (global bit1) even when no channel is active. Writing 1 to that bit leaves it as it is, and writing 0 clears it.
- R8: An NMI edge during a transfer drops `bus_req` by the next cycle. It produces no further bus cycles, and the interrupted unit is not counted.
- R9: No channel starts while the NMI flag is set or while the global enable (global bit0) is 0.
- R10: The engine drives bus cycles and advances only while `bus_gnt` is high. `bus_req` is held while the grant is withheld.
- R11: After reset all registers read 0, and `bus_req` and `eot_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_byte | input | 1 | Write is a byte access (low 8 bits) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| chan_req | input | 4 | External per-channel transfer requests |
| nmi_in | input | 1 | Non-maskable interrupt, edge sensitive |
| bus_req | output | 1 | DMA wants the bus |
| bus_gnt | input | 1 | Processor grants the bus |
| bus_rd | output | 1 | Read phase of a unit |
| bus_wr | output | 1 | Write phase of a unit |
| bus_ch | output | 2 | Channel owning the current cycle |
| bus_addr | output | 16 | Address of the current unit |
| eot_irq | output | 4 | One-cycle end-of-transfer pulse per channel |

## Verification
The hardest case is an NMI that arrives in the middle of a burst, between the read and write phases of a unit. If it arrives there, the unit must vanish from the count. The bench counts completed write phases as the scoreboard pops them. It waits until the third write has been seen and the next read phase is showing. It then raises `nmi_in` in that same half cycle. The bench then requires the bus request to be gone one cycle later and the count register to still hold seven of the ten units. Withholding the grant and the one-cycle gaps of cycle-steal are reached by a processor model that can hold back `bus_gnt`.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} eng_state_e;
  localparam logic [1:0] SRC_LINE = 2'd0;
  localparam logic [1:0] SRC_AUTO = 2'd1;
  localparam int CTRL_BITS = 5;
endpackage

// File: rtl/dma_global_regs.sv
module dma_global_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wd,
  input  logic       nmi_in,
  output logic       gen,
  output logic       nmif,
  output logic       nmi_rise
);
  logic nmi_q;

  assign nmi_rise = nmi_in && !nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      gen   <= 1'b0;
      nmif  <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      if (wr_en) gen <= wd[0];
      if (nmi_rise) nmif <= 1'b1;
      else if (wr_en && !wd[1]) nmif <= 1'b0;
    end
  end

  // R7: an edge always leaves the flag set
  p_nmi_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> nmif);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              cnt_we,
  input  logic              adr_we,
  input  logic              is_byte,
  input  logic [4:0]        ctrl_wd,
  input  logic [CNT_W-1:0]  cnt_wd,
  input  logic [ADDR_W-1:0] adr_wd,
  input  logic              unit_done,
  output logic              en,
  output logic              burst,
  output logic [1:0]        src,
  output logic              tend,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] adr,
  output logic              last,
  output logic              eot
);
  logic src_locked;

  assign last       = (cnt == CNT_W'(1));
  assign src_locked = en && (ctrl_wd[3:2] != src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      burst <= 1'b0;
      src   <= '0;
      tend  <= 1'b0;
      cnt   <= '0;
      adr   <= '0;
      eot   <= 1'b0;
    end else begin
      eot <= 1'b0;
      if (ctrl_we && !src_locked) begin
        en    <= ctrl_wd[0];
        burst <= ctrl_wd[1];
        src   <= ctrl_wd[3:2];
        if (!ctrl_wd[4]) tend <= 1'b0;
      end
      if (unit_done) begin
        cnt <= cnt - CNT_W'(1);
        adr <= adr + ADDR_W'(1);
        if (last) begin
          en   <= 1'b0;
          tend <= 1'b1;
          eot  <= 1'b1;
        end
      end else begin
        if (cnt_we && !is_byte) cnt <= cnt_wd;
        if (adr_we && !is_byte) adr <= adr_wd;
      end
    end
  end

  // R2: source select frozen while enabled
  p_src_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(src));
  // R6: end pulse lasts one cycle
  p_eot_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);
  // R6: pulse coincides with flag set and channel disabled
  p_eot_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (tend && !en));
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int N_CH = 4,
  parameter int IW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] req,
  output logic            any,
  output logic [IW-1:0]   idx
);
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pick_valid,
  input  logic [IW-1:0]   pick_idx,
  input  logic            stop,
  input  logic [N_CH-1:0] en_vec,
  input  logic [N_CH-1:0] burst_vec,
  input  logic [N_CH-1:0] last_vec,
  input  logic            bus_gnt,
  output logic            bus_req,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            unit_done,
  output logic [IW-1:0]   cur_ch
);
  eng_state_e state;
  logic       halt;

  assign halt      = stop || !en_vec[cur_ch];
  assign bus_req   = (state != ST_IDLE);
  assign bus_rd    = (state == ST_RD) && bus_gnt && !halt;
  assign bus_wr    = (state == ST_WR) && bus_gnt && !halt;
  assign unit_done = bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cur_ch <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (pick_valid) begin
          state  <= ST_REQ;
          cur_ch <= pick_idx;
        end
        ST_REQ: begin
          if (halt) state <= ST_IDLE;
          else if (bus_gnt) state <= ST_RD;
        end
        ST_RD: begin
          if (halt) state <= ST_IDLE;
          else if (bus_gnt) state <= ST_WR;
        end
        ST_WR: begin
          if (halt) state <= ST_IDLE;
          else if (bus_gnt) begin
            if (last_vec[cur_ch] || !burst_vec[cur_ch]) state <= ST_IDLE;
            else state <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a write phase only follows a read phase of the same unit
  p_rd_before_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> ($past(state) == ST_RD || $past(state) == ST_WR));
  // R4: cycle-steal hands the bus back after each unit
  p_cs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !burst_vec[cur_ch]) |=> !bus_req);
  // R6: the final unit releases the bus
  p_final_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && last_vec[cur_ch]) |=> !bus_req);
  // R8/R9: stop condition leaves no request pending
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !bus_req);
endmodule

// File: rtl/dma_busown_ctrl.sv
module dma_busown_ctrl
  import dma_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16,
  parameter int RA_W   = 8,
  parameter int DW     = 16,
  localparam int IW    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_byte,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [N_CH-1:0]   chan_req,
  input  logic              nmi_in,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [IW-1:0]     bus_ch,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [N_CH-1:0]   eot_irq
);
  localparam int BLK = 16;

  logic              gen, nmif, nmi_rise, stop;
  logic              glob_we, unit_done, pick_valid;
  logic [IW-1:0]     pick_idx, cur_ch;
  logic [N_CH-1:0]   en_v, burst_v, tend_v, last_v, elig, done_v;
  logic [1:0]        src_a [N_CH];
  logic [CNT_W-1:0]  cnt_a [N_CH];
  logic [ADDR_W-1:0] adr_a [N_CH];

  assign glob_we = reg_we && (reg_addr == '0);
  assign stop    = !gen || nmif || nmi_rise;

  dma_global_regs u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (glob_we),
    .wd       (reg_wdata[1:0]),
    .nmi_in   (nmi_in),
    .gen      (gen),
    .nmif     (nmif),
    .nmi_rise (nmi_rise)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [RA_W-1:0] BASE = RA_W'((c + 1) * BLK);
    logic src_ok;

    assign src_ok = (src_a[c] == SRC_LINE) ? chan_req[c] : (src_a[c] == SRC_AUTO);
    assign elig[c]   = en_v[c] && src_ok && (cnt_a[c] != '0) && !stop;
    assign done_v[c] = unit_done && (cur_ch == IW'(c));

    dma_chan_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (reg_we && (reg_addr == BASE)),
      .cnt_we    (reg_we && (reg_addr == BASE + RA_W'(4))),
      .adr_we    (reg_we && (reg_addr == BASE + RA_W'(8))),
      .is_byte   (reg_byte),
      .ctrl_wd   (reg_wdata[CTRL_BITS-1:0]),
      .cnt_wd    (reg_wdata[CNT_W-1:0]),
      .adr_wd    (reg_wdata[ADDR_W-1:0]),
      .unit_done (done_v[c]),
      .en        (en_v[c]),
      .burst     (burst_v[c]),
      .src       (src_a[c]),
      .tend      (tend_v[c]),
      .cnt       (cnt_a[c]),
      .adr       (adr_a[c]),
      .last      (last_v[c]),
      .eot       (eot_irq[c])
    );
  end

  dma_arbiter #(.N_CH(N_CH), .IW(IW)) u_arb (
    .req (elig),
    .any (pick_valid),
    .idx (pick_idx)
  );

  dma_engine #(.N_CH(N_CH), .IW(IW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .stop       (stop),
    .en_vec     (en_v),
    .burst_vec  (burst_v),
    .last_vec   (last_v),
    .bus_gnt    (bus_gnt),
    .bus_req    (bus_req),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .unit_done  (unit_done),
    .cur_ch     (cur_ch)
  );

  assign bus_ch   = cur_ch;
  assign bus_addr = adr_a[cur_ch];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = DW'({nmif, gen});
    for (int c = 0; c < N_CH; c++) begin
      if (reg_addr == RA_W'((c + 1) * BLK))
        reg_rdata = DW'({tend_v[c], src_a[c], burst_v[c], en_v[c]});
      if (reg_addr == RA_W'((c + 1) * BLK + 4)) reg_rdata = DW'(cnt_a[c]);
      if (reg_addr == RA_W'((c + 1) * BLK + 8)) reg_rdata = DW'(adr_a[c]);
    end
  end

  // R5: channel 0 wins whenever it is eligible
  p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    elig[0] |-> (pick_valid && pick_idx == '0));
  // R6: completions never overlap
  p_eot_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eot_irq));
endmodule

// File: tb/tb_dma_busown_ctrl.sv
module tb_dma_busown_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_byte = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  chan_req = '0;
  logic        nmi_in = 1'b0;
  logic        bus_req, bus_gnt, bus_rd, bus_wr;
  logic [1:0]  bus_ch;
  logic [15:0] bus_addr;
  logic [3:0]  eot_irq;
  logic        cpu_allow = 1'b1;

  int n_checks = 0, n_err = 0;
  int rises = 0, wr_cnt = 0;
  int eot_cnt [4] = '{0, 0, 0, 0};
  logic [3:0] eot_prev = '0;
  logic       req_prev = 1'b0;
  logic [17:0] exp_q [$];

  dma_busown_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_byte(reg_byte),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chan_req(chan_req), .nmi_in(nmi_in), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ch(bus_ch), .bus_addr(bus_addr),
    .eot_irq(eot_irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_byte = b;
    @(negedge clk);
    reg_we = 1'b0; reg_byte = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_units(input logic [1:0] ch, input logic [15:0] a0, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back({ch, a0 + 16'(i)});
  endtask

  task automatic wait_quiet(input string tag);
    int n;
    n = 0;
    do begin
      @(negedge clk); #1; n++;
    end while ((exp_q.size() != 0 || bus_req) && n < 3000);
    check(tag, exp_q.size(), 0);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // processor model: grant follows request shortly after each edge
  initial begin
    bus_gnt = 1'b0;
    forever begin
      @(posedge clk);
      #2 bus_gnt = bus_req && cpu_allow;
    end
  end

  // monitor: scoreboard for write phases, request edges, end pulses
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !req_prev) rises++;
      req_prev = bus_req;
      for (int c = 0; c < 4; c++) begin
        if (eot_irq[c]) begin
          eot_cnt[c]++;
          if (eot_prev[c]) check("R6 eot width", 2, 1);
        end
      end
      eot_prev = eot_irq;
      if (bus_wr) begin
        wr_cnt++;
        if (exp_q.size() == 0) check("R3 unexpected unit", {14'd0, bus_ch, bus_addr}, 32'hFFFF_FFFF);
        else check("R3/R5 scoreboard ch,addr", {14'd0, bus_ch, bus_addr}, {14'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("R-all watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(1);

    // R11 reset state
    check("R11 bus_req", bus_req, 0);
    check("R11 eot_irq", eot_irq, 0);
    reg_read(8'h00, v); check("R11 global", v, 0);
    reg_read(8'h10, v); check("R11 ch0 ctrl", v, 0);
    reg_read(8'h14, v); check("R11 ch0 count", v, 0);

    // R3/R6 burst on ch1, auto-request
    push_units(2'd1, 16'h0100, 3);
    reg_write(8'h24, 16'd3, 1'b0);
    reg_write(8'h28, 16'h0100, 1'b0);
    reg_write(8'h20, 16'h0007, 1'b0);
    rises = 0;
    reg_write(8'h00, 16'h0001, 1'b0);
    wait_quiet("R3 burst drained");
    check("R3 burst single request", rises, 1);
    check("R6 ch1 eot count", eot_cnt[1], 1);
    reg_read(8'h20, v); check("R6 ch1 ctrl after end", v, 16'h0016);
    reg_read(8'h24, v); check("R6 ch1 count zero", v, 0);
    reg_read(8'h28, v); check("R3 ch1 address advanced", v, 16'h0103);

    // R4 cycle-steal on ch2, request line
    chan_req[2] = 1'b1;
    push_units(2'd2, 16'h0200, 3);
    reg_write(8'h34, 16'd3, 1'b0);
    reg_write(8'h38, 16'h0200, 1'b0);
    rises = 0;
    reg_write(8'h30, 16'h0001, 1'b0);
    wait_quiet("R4 cycle-steal drained");
    check("R4 request edges per unit", rises, 3);
    check("R6 ch2 eot count", eot_cnt[2], 1);
    chan_req[2] = 1'b0;

    // R5 priority: ch0 and ch3 ready together
    reg_write(8'h00, 16'h0000, 1'b0);
    reg_write(8'h14, 16'd2, 1'b0);
    reg_write(8'h18, 16'h0300, 1'b0);
    reg_write(8'h10, 16'h0005, 1'b0);
    reg_write(8'h44, 16'd2, 1'b0);
    reg_write(8'h48, 16'h0400, 1'b0);
    reg_write(8'h40, 16'h0005, 1'b0);
    push_units(2'd0, 16'h0300, 2);
    push_units(2'd3, 16'h0400, 2);
    rises = 0;
    reg_write(8'h00, 16'h0001, 1'b0);
    wait_quiet("R5 priority drained");
    check("R4 priority run request edges", rises, 4);

    // R2 source lock, R9 global enable off
    reg_write(8'h00, 16'h0000, 1'b0);
    reg_write(8'h30, 16'h0001, 1'b0);
    reg_read(8'h30, v); check("R2 ch2 enabled, line source", v, 16'h0001);
    reg_write(8'h30, 16'h0005, 1'b0);
    reg_read(8'h30, v); check("R2 source change while enabled ignored", v, 16'h0001);
    rises = 0;
    chan_req[2] = 1'b1;
    wait_cycles(6);
    check("R9 no start with global enable 0", rises, 0);
    chan_req[2] = 1'b0;
    reg_write(8'h30, 16'h0000, 1'b0);
    reg_write(8'h30, 16'h0004, 1'b0);
    reg_read(8'h30, v); check("R2 source change while disabled", v, 16'h0004);

    // R1 byte-access rules
    reg_write(8'h34, 16'd5, 1'b0);
    reg_write(8'h34, 16'h0009, 1'b1);
    reg_read(8'h34, v); check("R1 byte write to count ignored", v, 16'd5);
    reg_write(8'h38, 16'h1234, 1'b0);
    reg_write(8'h38, 16'h0077, 1'b1);
    reg_read(8'h38, v); check("R1 byte write to address ignored", v, 16'h1234);
    reg_write(8'h30, 16'h0008, 1'b1);
    reg_read(8'h30, v); check("R1 byte write to control", v, 16'h0008);
    reg_write(8'h00, 16'h0001, 1'b1);
    reg_read(8'h00, v); check("R1 byte write to global", v, 16'h0001);
    reg_write(8'h00, 16'h0000, 1'b1);

    // R7 NMI while idle, R9 blocked while flagged
    nmi_in = 1'b1; wait_cycles(2); nmi_in = 1'b0;
    reg_read(8'h00, v); check("R7 flag set while idle", v, 16'h0002);
    reg_write(8'h00, 16'h0003, 1'b0);
    reg_read(8'h00, v); check("R7 write 1 keeps flag", v, 16'h0003);
    push_units(2'd0, 16'h0500, 2);
    reg_write(8'h14, 16'd2, 1'b0);
    reg_write(8'h18, 16'h0500, 1'b0);
    rises = 0;
    reg_write(8'h10, 16'h0005, 1'b0);
    wait_cycles(20);
    check("R9 no start while flag set", rises, 0);
    check("R9 units still pending", exp_q.size(), 2);
    reg_write(8'h00, 16'h0001, 1'b0);
    wait_quiet("R7 resume after clear");
    reg_read(8'h00, v); check("R7 flag cleared by write 0", v, 16'h0001);

    // R8 NMI abort inside a burst
    push_units(2'd1, 16'h0600, 10);
    reg_write(8'h24, 16'd10, 1'b0);
    reg_write(8'h28, 16'h0600, 1'b0);
    base = wr_cnt;
    reg_write(8'h20, 16'h0007, 1'b0);
    do begin @(negedge clk); #1; end while (!(wr_cnt >= base + 3 && bus_rd));
    nmi_in = 1'b1;
    @(negedge clk); #1;
    check("R8 request dropped", bus_req, 0);
    check("R8 units before abort", wr_cnt - base, 3);
    exp_q.delete();
    reg_read(8'h24, v); check("R8 interrupted unit not counted", v, 16'd7);
    base = wr_cnt;
    wait_cycles(10);
    check("R8 no cycles after abort", wr_cnt - base, 0);
    nmi_in = 1'b0;
    reg_read(8'h00, v); check("R7 flag set by abort", v, 16'h0003);
    reg_write(8'h20, 16'h0004, 1'b0);
    reg_write(8'h00, 16'h0001, 1'b0);

    // R10 grant withheld
    cpu_allow = 1'b0;
    push_units(2'd0, 16'h0700, 1);
    reg_write(8'h14, 16'd1, 1'b0);
    reg_write(8'h18, 16'h0700, 1'b0);
    base = wr_cnt;
    reg_write(8'h10, 16'h0005, 1'b0);
    wait_cycles(10);
    check("R10 request held without grant", bus_req, 1);
    check("R10 no cycles without grant", wr_cnt - base, 0);
    cpu_allow = 1'b1;
    wait_quiet("R10 unit after grant");
    check("R10 one unit after grant", wr_cnt - base, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule